// File: doc/BRIEF.md
# Synthesizer Bring-Up Sequencer

This block is a power-up controller for a fractional-N frequency synthesizer. After reset it holds off for a settling interval so the analog supplies can stabilize. It then drives a separate serial word writer through a simple command handshake: it presents a word and its bit length, pulses a go strobe, and waits for an acknowledge before presenting the next command. No two writes ever overlap.

The writes follow a fixed order of six. The noise/spur register is first cleared and then loaded. The control word is written with its counter-reset bit held high. The reference divider and the feedback divider are loaded next. The control word is then written again with the counter-reset bit low, which releases the counters. The four register words are parameters, so a different output frequency only needs different parameter values. Once the sixth write is acknowledged, a done flag rises and stays high. From then on a lock LED follows the synthesizer's lock-detect input, taken through a two-stage synchronizer.

Top module: `synth_boot_seq`

## Requirements
- R1: After reset is released, no write is started until the settle timer has counted SETTLE_CYCLES clocks. The first go strobe appears 1 to 2 cycles after that count. During the wait, cfg_done and lock_led stay low.
- R2: The first write carries word 0x000003 with length 11.
- R3: The second write carries NS_WORD (default 0x0003C7) with length 11.
- R4: The third write carries CTRL_WORD with bit 3 forced to 1 (default result 0x0001EA) with length 16.
- R5: The fourth write carries REF_WORD (default 0x1440A1) with length 24. The fifth write carries FB_WORD (default 0x3FC060) with length 24.
- R6: The sixth write carries CTRL_WORD with bit 3 forced to 0 (default result 0x0001E2) with length 16. When that write is acknowledged, cfg_done goes high and stays high until reset.
- R7: wr_go is a pulse one cycle long. After a pulse, no further pulse occurs until wr_ack has been seen. wr_word and wr_len stay stable while the write is outstanding.
- R8: Before cfg_done is high, lock_led is low. Once cfg_done is high, lock_led equals lock_det delayed by three clocks.
- R9: Asserting rst at any point abandons the sequence. After release, the block restarts from the settling wait and replays all six writes.
- R10: After cfg_done, no further write is started, including when a stray wr_ack arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ack | input | 1 | Writer reports that the current word has been shifted out and latched |
| lock_det | input | 1 | Lock-detect level from the synthesizer, asynchronous |
| wr_go | output | 1 | One-cycle strobe that starts a write |
| wr_len | output | 5 | Number of bits to send, counted from the word's LSB end |
| wr_word | output | 24 | Word to send, right-aligned |
| cfg_done | output | 1 | High once all six writes have been acknowledged |
| lock_led | output | 1 | Lock indicator, low until configuration is finished |

## Verification
The bench builds the block with SETTLE_CYCLES set to 40 instead of the full 100 ms count. This makes the settling wait, a full bring-up and a second bring-up after a mid-run reset fit in a few hundred cycles. The register words keep their default values, so the bench checks the exact words the default frequency needs, including both forms of the control word. The acknowledge delay is different for every write, which shows that the sequencer waits on the handshake and not on a fixed cycle count.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int WORD_W      = 24;
    localparam int LEN_W       = 5;
    localparam int NUM_STEPS   = 6;
    localparam int STEP_W      = $clog2(NUM_STEPS);
    localparam int CNT_RST_BIT = 3;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_ISSUE,
        ST_WAIT_ACK,
        ST_LIVE
    } boot_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] word;
    } wr_cmd_t;

    function automatic wr_cmd_t pick_cmd(
        input logic [STEP_W-1:0] idx,
        input logic [WORD_W-1:0] ns_w,
        input logic [WORD_W-1:0] ctl_w,
        input logic [WORD_W-1:0] ref_w,
        input logic [WORD_W-1:0] fb_w
    );
        wr_cmd_t c;
        logic [WORD_W-1:0] ctl_hold;
        logic [WORD_W-1:0] ctl_run;
        ctl_hold = ctl_w | (WORD_W'(1) << CNT_RST_BIT);
        ctl_run  = ctl_w & ~(WORD_W'(1) << CNT_RST_BIT);
        case (idx)
            STEP_W'(0): c = '{len: LEN_W'(11), word: WORD_W'(3)};
            STEP_W'(1): c = '{len: LEN_W'(11), word: ns_w};
            STEP_W'(2): c = '{len: LEN_W'(16), word: ctl_hold};
            STEP_W'(3): c = '{len: LEN_W'(24), word: ref_w};
            STEP_W'(4): c = '{len: LEN_W'(24), word: fb_w};
            default:    c = '{len: LEN_W'(16), word: ctl_run};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          settled_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            settled_q <= 1'b0;
        end else if (!settled_q) begin
            if (cnt_q == CW'(SETTLE_CYCLES - 1)) begin
                settled_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign settled = settled_q;

    // R1
    settled_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        settled |=> settled);

endmodule

// File: rtl/write_sequencer.sv
module write_sequencer
    import boot_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] NS_WORD   = 24'h0003C7,
    parameter logic [WORD_W-1:0] CTRL_WORD = 24'h0001E2,
    parameter logic [WORD_W-1:0] REF_WORD  = 24'h1440A1,
    parameter logic [WORD_W-1:0] FB_WORD   = 24'h3FC060
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              settled,
    input  logic              wr_ack,
    output logic              wr_go,
    output logic [LEN_W-1:0]  wr_len,
    output logic [WORD_W-1:0] wr_word,
    output logic              cfg_done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    boot_state_e       state_q;
    logic [STEP_W-1:0] idx_q;
    wr_cmd_t           cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SETTLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_SETTLE:   if (settled) state_q <= ST_ISSUE;
                ST_ISSUE:    state_q <= ST_WAIT_ACK;
                ST_WAIT_ACK: if (wr_ack) begin
                    if (idx_q == LAST_STEP) begin
                        state_q <= ST_LIVE;
                    end else begin
                        idx_q   <= idx_q + STEP_W'(1);
                        state_q <= ST_ISSUE;
                    end
                end
                default:     state_q <= ST_LIVE;
            endcase
        end
    end

    always_comb begin
        cmd = pick_cmd(idx_q, NS_WORD, CTRL_WORD, REF_WORD, FB_WORD);
    end

    assign wr_go    = (state_q == ST_ISSUE);
    assign wr_len   = cmd.len;
    assign wr_word  = cmd.word;
    assign cfg_done = (state_q == ST_LIVE);

    // R7
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !wr_go);

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go || (state_q == ST_WAIT_ACK && !wr_ack)) |=> ($stable(wr_word) && $stable(wr_len)));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);

    // R10
    no_go_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> !wr_go);

endmodule

// File: rtl/lock_follower.sv
module lock_follower (
    input  logic clk,
    input  logic rst,
    input  logic cfg_done,
    input  logic lock_det,
    output logic lock_led
);
    logic [1:0] sync_q;
    logic       led_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            led_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], lock_det};
            led_q  <= cfg_done & sync_q[1];
        end
    end

    assign lock_led = led_q;

    // R8
    led_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> !lock_led);

endmodule

// File: rtl/synth_boot_seq.sv
module synth_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int                SETTLE_CYCLES = 12_500_000,
    parameter logic [WORD_W-1:0] NS_WORD       = 24'h0003C7,
    parameter logic [WORD_W-1:0] CTRL_WORD     = 24'h0001E2,
    parameter logic [WORD_W-1:0] REF_WORD      = 24'h1440A1,
    parameter logic [WORD_W-1:0] FB_WORD       = 24'h3FC060
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ack,
    input  logic              lock_det,
    output logic              wr_go,
    output logic [LEN_W-1:0]  wr_len,
    output logic [WORD_W-1:0] wr_word,
    output logic              cfg_done,
    output logic              lock_led
);
    logic settled;

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .settled (settled)
    );

    write_sequencer #(
        .NS_WORD   (NS_WORD),
        .CTRL_WORD (CTRL_WORD),
        .REF_WORD  (REF_WORD),
        .FB_WORD   (FB_WORD)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .settled  (settled),
        .wr_ack   (wr_ack),
        .wr_go    (wr_go),
        .wr_len   (wr_len),
        .wr_word  (wr_word),
        .cfg_done (cfg_done)
    );

    lock_follower i_lock (
        .clk      (clk),
        .rst      (rst),
        .cfg_done (cfg_done),
        .lock_det (lock_det),
        .lock_led (lock_led)
    );

    // R1
    wait_settle_chk: assert property (@(posedge clk) disable iff (rst)
        !settled |-> (!wr_go && !cfg_done));

endmodule

// File: tb/test_synth_boot_seq.sv
module test_synth_boot_seq;

    localparam int SETTLE = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_ack;
    logic        lock_det;
    logic        wr_go;
    logic [4:0]  wr_len;
    logic [23:0] wr_word;
    logic        cfg_done;
    logic        lock_led;

    int vectors = 0;
    int miscompares = 0;

    // expected {len, word} per write: R2, R3, R4, R5, R5, R6
    localparam logic [28:0] EXP_TBL [6] = '{
        {5'd11, 24'h000003},
        {5'd11, 24'h0003C7},
        {5'd16, 24'h0001EA},
        {5'd24, 24'h1440A1},
        {5'd24, 24'h3FC060},
        {5'd16, 24'h0001E2}
    };

    always #4 clk = ~clk;

    synth_boot_seq #(.SETTLE_CYCLES(SETTLE)) i_synth_boot_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_ack   (wr_ack),
        .lock_det (lock_det),
        .wr_go    (wr_go),
        .wr_len   (wr_len),
        .wr_word  (wr_word),
        .cfg_done (cfg_done),
        .lock_led (lock_led)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_go(output int cyc);
        cyc = 0;
        while (wr_go !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_writes(input int n, input int dly_base);
        int c;
        for (int k = 0; k < n; k++) begin
            logic extra_go;
            logic moved;
            logic [23:0] w0;
            logic [4:0]  l0;
            wait_go(c);
            check((k == 0) ? "R2" : (k == 1) ? "R3" : (k == 2) ? "R4" : (k == 5) ? "R6" : "R5",
                  {3'b0, wr_len, wr_word}, {3'b0, EXP_TBL[k]});
            w0 = wr_word;
            l0 = wr_len;
            extra_go = 1'b0;
            moved = 1'b0;
            for (int d = 0; d < dly_base + 2 * k; d++) begin
                @(negedge clk);
                if (wr_go) extra_go = 1'b1;
                if (wr_word !== w0 || wr_len !== l0) moved = 1'b1;
            end
            check("R7 no go while busy", {31'b0, extra_go}, 32'd0);
            check("R7 word held", {31'b0, moved}, 32'd0);
            wr_ack = 1'b1;
            @(negedge clk);
            wr_ack = 1'b0;
        end
    endtask

    task automatic settle_phase;
        int c;
        logic early;
        c = 0;
        early = 1'b0;
        while (wr_go !== 1'b1 && c < 2000) begin
            if (cfg_done || lock_led) early = 1'b1;
            @(negedge clk);
            c++;
        end
        check("R1 outputs low while settling", {31'b0, early}, 32'd0);
        vectors++;
        if (c < SETTLE + 1 || c > SETTLE + 2) begin
            miscompares++;
            $display("FAIL R1 first go at cycle actual=%0d expected=%0d..%0d", c, SETTLE + 1, SETTLE + 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic seen;
        rst = 1'b1;
        wr_ack = 1'b0;
        lock_det = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset go", {31'b0, wr_go}, 32'd0);
        check("R1 reset done", {31'b0, cfg_done}, 32'd0);
        check("R8 reset led", {31'b0, lock_led}, 32'd0);

        lock_det = 1'b1;
        rst = 1'b0;
        settle_phase();
        run_writes(6, 1);
        check("R6 done after last ack", {31'b0, cfg_done}, 32'd1);

        repeat (4) @(negedge clk);
        check("R8 led follows lock high", {31'b0, lock_led}, 32'd1);
        lock_det = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 led follows lock low", {31'b0, lock_led}, 32'd0);
        lock_det = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 led relock", {31'b0, lock_led}, 32'd1);

        seen = 1'b0;
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wr_go) seen = 1'b1;
        end
        check("R10 no go after done", {31'b0, seen}, 32'd0);
        check("R6 done stays high", {31'b0, cfg_done}, 32'd1);

        // abort midway through a second bring-up
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        settle_phase();
        run_writes(3, 3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 done cleared by reset", {31'b0, cfg_done}, 32'd0);
        check("R9 led cleared by reset", {31'b0, lock_led}, 32'd0);
        rst = 1'b0;
        settle_phase();
        run_writes(6, 2);
        check("R9 done after replay", {31'b0, cfg_done}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule